// File: doc/BRIEF.md
# Programmable-Increment System Time Counter

This block keeps a 64-bit free-running time-of-day value for hardware timestamping logic. The counter does not step by one each cycle. It adds a programmable increment once every N input clock cycles, where N is a programmable period. Software scales the increment so that the lower bits of the counter hold fractions of a nanosecond. Small changes to the increment then give fine frequency trims, and the period is kept as short as the clock allows.

Software reaches the counter through a plain register port with one write strobe and one read strobe. The time is seen as two 32-bit words, and a third word holds the period and the increment. Reading the low word freezes a copy of the high word, so a low-then-high read pair always yields one coherent 64-bit sample. Writing the low word only stages it. Writing the high word then loads both words into the counter in a single cycle. When an increment carries out of the top bit, the block raises a one-cycle wrap pulse.

Top module: `systime_counter`

## Requirements
- R1: After reset the time is 0, the control word is 0 (counting stopped), `rdata` is 0 and `time_wrap` is low.
- R2: The control word at address 2 holds the period in bits 31:24 and the increment in bits 23:0. Reading address 2 returns the value last written.
- R3: With period P other than 0, the counter adds the increment on every P-th clock edge after the last phase restart. On every other edge it holds its value.
- R4: A period of 0 stops the counter, which then holds its value.
- R5: Reading address 0 returns the live low word and copies the live high word into a shadow. Reading address 1 returns that shadow, even if the time has been reloaded since.
- R6: Writing address 0 only stages the value and leaves the counter unchanged. Writing address 1 loads {written high word, staged low word} on that edge and restarts the period phase.
- R7: Writing the control word restarts the period phase, so no increment happens on that edge. The first increment with the new settings comes P edges later.
- R8: The counter wraps modulo 2^64 without saturating. An increment that carries out of bit 63 raises `time_wrap` for exactly the following cycle.
- R9: Read data appears on `rdata` in the cycle after `rd_en`. Address 3 reads as 0, and writes to it change nothing.
- R10: The scaled settings (period 1, increment 40<<18), (period 3, increment 125<<17) and (period 3, increment 125<<14) all fit the control word. Over many periods each advances the time by the exact product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the register port |
| rd_en | input | 1 | Read strobe for the register port |
| addr | input | 2 | Word select: 0 time low, 1 time high, 2 control, 3 unused |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| time_wrap | output | 1 | One-cycle pulse when the counter wraps past 2^64 |

## Verification
The bench builds the block with its 64-bit time, 8-bit period and 24-bit increment, and selects the split-carry adder variant. Because the port can load any 64-bit time, the bench can start the counter just below 2^64 and observe a wrap within a cycle. It also checks whole runs of 100 to 1000 periods against the three scaled settings. Random periods, increments, start times and idle gaps exercise the phase arithmetic. Directed steps cover a control write landing on a phase boundary and a shadow read taken across a reload.

// File: rtl/systime_pkg.sv
package systime_pkg;

   localparam int CTL_PER_W = 8;
   localparam int CTL_INC_W = 24;

   typedef enum logic [1:0] {
      SEL_TIME_LO = 2'd0,
      SEL_TIME_HI = 2'd1,
      SEL_CTL     = 2'd2,
      SEL_UNUSED  = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic [CTL_PER_W-1:0] period;
      logic [CTL_INC_W-1:0] incr;
   } ctl_word_t;

endpackage

// File: rtl/systime_tick_gen.sv
module systime_tick_gen #(
   parameter int PER_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PER_W-1:0] period,
   input  logic             restart,
   output logic             step_o
);

   logic [PER_W-1:0] phase_q;
   logic             running;
   logic             at_end;

   assign running = (period != '0);
   assign at_end  = running && (phase_q == period - PER_W'(1));
   assign step_o  = at_end && !restart;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
      end else if (restart || !running || at_end) begin
         phase_q <= '0;
      end else begin
         phase_q <= phase_q + PER_W'(1);
      end
   end

   // phase stays inside the current period window
   assert_phase_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> (phase_q < period));

   // a restart edge never advances and leaves phase at zero
   assert_restart_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (phase_q == '0));

endmodule

// File: rtl/systime_accum.sv
module systime_accum #(
   parameter int TIME_W    = 64,
   parameter int INC_W     = 24,
   parameter bit SPLIT_ADD = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic [INC_W-1:0]  incr,
   input  logic              load,
   input  logic [TIME_W-1:0] load_val,
   output logic [TIME_W-1:0] time_o,
   output logic              wrap_o
);

   localparam int HALF_W = TIME_W / 2;
   localparam int TOP_W  = TIME_W - HALF_W;

   logic [TIME_W-1:0] sum;
   logic              carry;

   generate
      if (INC_W > HALF_W) begin : g_bad_width
         $error("increment wider than half the time word");
      end
      if (SPLIT_ADD) begin : g_split
         logic [HALF_W:0] lo_sum;
         logic [TOP_W:0]  hi_sum;
         assign lo_sum = {1'b0, time_o[HALF_W-1:0]} + (HALF_W+1)'(incr);
         assign hi_sum = {1'b0, time_o[TIME_W-1:HALF_W]} + (TOP_W+1)'(lo_sum[HALF_W]);
         assign sum    = {hi_sum[TOP_W-1:0], lo_sum[HALF_W-1:0]};
         assign carry  = hi_sum[TOP_W];
      end else begin : g_flat
         logic [TIME_W:0] full_sum;
         assign full_sum = {1'b0, time_o} + (TIME_W+1)'(incr);
         assign sum      = full_sum[TIME_W-1:0];
         assign carry    = full_sum[TIME_W];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         time_o <= '0;
         wrap_o <= 1'b0;
      end else if (load) begin
         time_o <= load_val;
         wrap_o <= 1'b0;
      end else if (step) begin
         time_o <= sum;
         wrap_o <= carry;
      end else begin
         wrap_o <= 1'b0;
      end
   end

   // without a step or load the time holds
   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !load) |=> $stable(time_o));

   // a wrap leaves a residue smaller than the increment that caused it
   assert_wrap_residue_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_o |-> (time_o < TIME_W'($past(incr))));

   // the wrap flag never lasts two cycles
   assert_wrap_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_o |=> !wrap_o);

endmodule

// File: rtl/systime_regif.sv
module systime_regif
   import systime_pkg::*;
#(
   parameter int        WORD_W  = 32,
   parameter int        TIME_W  = 64,
   parameter logic [31:0] RST_CTL = 32'h0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [1:0]        addr,
   input  logic [WORD_W-1:0] wdata,
   input  logic [TIME_W-1:0] time_i,
   output logic [WORD_W-1:0] rdata,
   output ctl_word_t         ctl_o,
   output logic              ctl_wr_o,
   output logic              load_o,
   output logic [TIME_W-1:0] load_val_o
);

   localparam int CTL_W = CTL_PER_W + CTL_INC_W;

   generate
      if (TIME_W != 2 * WORD_W) begin : g_bad_split
         $error("time must span exactly two register words");
      end
      if (CTL_W != WORD_W) begin : g_bad_ctl
         $error("control word must match the register width");
      end
   endgenerate

   reg_sel_e          sel;
   logic [WORD_W-1:0] staged_q;
   logic [WORD_W-1:0] shadow_q;

   assign sel        = reg_sel_e'(addr);
   assign ctl_wr_o   = wr_en && (sel == SEL_CTL);
   assign load_o     = wr_en && (sel == SEL_TIME_HI);
   assign load_val_o = {wdata, staged_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         staged_q <= '0;
         ctl_o    <= ctl_word_t'(RST_CTL);
      end else if (wr_en) begin
         case (sel)
            SEL_TIME_LO: staged_q <= wdata;
            SEL_CTL:     ctl_o    <= ctl_word_t'(wdata);
            default:     ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata    <= '0;
         shadow_q <= '0;
      end else if (rd_en) begin
         case (sel)
            SEL_TIME_LO: begin
               rdata    <= time_i[WORD_W-1:0];
               shadow_q <= time_i[TIME_W-1:WORD_W];
            end
            SEL_TIME_HI: rdata <= shadow_q;
            SEL_CTL:     rdata <= WORD_W'(ctl_o);
            default:     rdata <= '0;
         endcase
      end
   end

   // low read captures the high half of the same sample
   assert_shadow_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && sel == SEL_TIME_LO) |=> (shadow_q == $past(time_i[TIME_W-1:WORD_W])));

   // high write lands both words in the counter on that edge
   assert_atomic_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      load_o |=> (time_i == $past(load_val_o)));

   // control word only moves on its own write
   assert_ctl_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_wr_o |=> $stable(ctl_o));

endmodule

// File: rtl/systime_counter.sv
module systime_counter
   import systime_pkg::*;
#(
   parameter int          WORD_W    = 32,
   parameter int          TIME_W    = 64,
   parameter bit          SPLIT_ADD = 1'b0,
   parameter logic [31:0] RST_CTL   = 32'h0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [1:0]        addr,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] rdata,
   output logic              time_wrap
);

   ctl_word_t         ctl;
   logic              ctl_wr;
   logic              load;
   logic [TIME_W-1:0] load_val;
   logic [TIME_W-1:0] time_q;
   logic              step;

   systime_regif #(
      .WORD_W (WORD_W),
      .TIME_W (TIME_W),
      .RST_CTL(RST_CTL)
   ) u_regif (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .rd_en     (rd_en),
      .addr      (addr),
      .wdata     (wdata),
      .time_i    (time_q),
      .rdata     (rdata),
      .ctl_o     (ctl),
      .ctl_wr_o  (ctl_wr),
      .load_o    (load),
      .load_val_o(load_val)
   );

   systime_tick_gen #(
      .PER_W(CTL_PER_W)
   ) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .period (ctl.period),
      .restart(ctl_wr || load),
      .step_o (step)
   );

   systime_accum #(
      .TIME_W   (TIME_W),
      .INC_W    (CTL_INC_W),
      .SPLIT_ADD(SPLIT_ADD)
   ) u_accum (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (step),
      .incr    (ctl.incr),
      .load    (load),
      .load_val(load_val),
      .time_o  (time_q),
      .wrap_o  (time_wrap)
   );

   // stopped period freezes the time unless software reloads it
   assert_stopped_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.period == '0 && !load) |=> $stable(time_q));

   // a control write edge never advances the time
   assert_ctl_write_no_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr |=> $stable(time_q));

endmodule

// File: tb/systime_counter_tb.sv
`timescale 1ns/1ps
module systime_counter_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [1:0]  addr = 2'd0;
   logic [31:0] wdata = 32'd0;
   logic [31:0] rdata;
   logic        time_wrap;

   int checks = 0;
   int bad = 0;

   always #2 clk = ~clk;

   systime_counter #(.SPLIT_ADD(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .time_wrap(time_wrap)
   );

   function automatic logic [63:0] expect_time(logic [63:0] t0, int idle,
                                                int per, logic [23:0] inc);
      logic [63:0] adds;
      if (per == 0) return t0;
      adds = 64'(idle / per);
      return t0 + adds * 64'(inc);
   endfunction

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] a, logic [31:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(logic [1:0] a, output logic [31:0] d);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   task automatic load_time(logic [63:0] t);
      wr(2'd0, t[31:0]);
      wr(2'd1, t[63:32]);
   endtask

   task automatic set_ctl(int per, logic [23:0] inc);
      wr(2'd2, {8'(per), inc});
   endtask

   task automatic read_time(output logic [63:0] t);
      logic [31:0] lo, hi;
      rd(2'd0, lo);
      rd(2'd1, hi);
      t = {hi, lo};
   endtask

   task automatic run_case(string req, int per, logic [23:0] inc,
                           logic [63:0] t0, int idle);
      logic [63:0] got;
      set_ctl(per, inc);
      load_time(t0);
      repeat (idle) @(negedge clk);
      read_time(got);
      check(req, got, expect_time(t0, idle, per, inc));
   endtask

   initial begin
      logic [31:0] w;
      logic [63:0] t;
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      check("R1 rdata", 64'(rdata), 64'd0);
      check("R1 wrap", 64'(time_wrap), 64'd0);
      rd(2'd2, w);
      check("R1 ctl", 64'(w), 64'd0);
      repeat (5) @(negedge clk);
      read_time(t);
      check("R1 time", t, 64'd0);

      // R2 control layout and readback
      set_ctl(8'hA5, 24'h123456);
      rd(2'd2, w);
      check("R2 readback", 64'(w), 64'hA512_3456);

      // R9 address 3 write ignored, reads zero
      wr(2'd3, 32'hFFFF_FFFF);
      rd(2'd2, w);
      check("R9 unused write", 64'(w), 64'hA512_3456);
      rd(2'd3, w);
      check("R9 unused read", 64'(w), 64'd0);

      // R3 directed periods
      run_case("R3 per1", 1, 24'd7, 64'd100, 10);
      run_case("R3 per4", 4, 24'd9, 64'hFFFF_0000_0000, 13);
      run_case("R3 per255", 255, 24'hABCDEF, 64'd5, 600);

      // R4 stopped period
      run_case("R4 stopped", 0, 24'hFFFFFF, 64'h1234_5678_9ABC_DEF0, 37);

      // R6 low write only stages
      set_ctl(0, 24'd1);
      load_time(64'h0000_0011_0000_0022);
      wr(2'd0, 32'hDEAD_BEEF);
      read_time(t);
      check("R6 staged only", t, 64'h0000_0011_0000_0022);
      wr(2'd1, 32'h0000_0077);
      read_time(t);
      check("R6 atomic load", t, 64'h0000_0077_DEAD_BEEF);

      // R5 shadow survives a reload
      rd(2'd0, w);
      check("R5 low live", 64'(w), 64'hDEAD_BEEF);
      load_time(64'h9999_9999_0000_0000);
      rd(2'd1, w);
      check("R5 shadow", 64'(w), 64'h0000_0077);

      // R7 control write on a would-be boundary restarts the phase
      set_ctl(3, 24'd1000);
      load_time(64'd50);
      repeat (2) @(negedge clk);
      set_ctl(3, 24'd5);
      repeat (7) @(negedge clk);
      read_time(t);
      check("R7 phase restart", t, 64'd50 + 64'd10);

      // R8 wrap pulse
      set_ctl(1, 24'd40 << 18);
      load_time(64'd0 - 64'(24'd40 << 18));
      check("R8 no early wrap", 64'(time_wrap), 64'd0);
      @(negedge clk);
      check("R8 wrap pulse", 64'(time_wrap), 64'd1);
      @(negedge clk);
      check("R8 wrap single", 64'(time_wrap), 64'd0);
      run_case("R8 modulo", 2, 24'hFFFFFF, 64'hFFFF_FFFF_FFFF_FFF0, 8);

      // R10 scaled settings
      run_case("R10 cfg25", 1, 24'(40 << 18), 64'd0, 1000);
      run_case("R10 cfg96", 3, 24'(125 << 17), 64'd123, 300);
      run_case("R10 cfg24", 3, 24'(125 << 14), 64'hF000_0000_0000_0000, 300);

      // R3 random mix
      for (int i = 0; i < 24; i++) begin
         int per;
         int idle;
         logic [23:0] inc;
         logic [63:0] t0;
         per  = (i % 6 == 5) ? int'($urandom_range(0, 255)) : int'($urandom_range(1, 8));
         inc  = 24'($urandom);
         t0   = {$urandom, $urandom};
         idle = int'($urandom_range(0, 60));
         run_case("R3 random", per, inc, t0, idle);
      end

      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      #(4 * 200000);
      bad++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

endmodule